// File: doc/BRIEF.md
# Fixed-Rotation Shared-Memory Slot Arbiter

Eight processor cores share one memory through this arbiter. A free-running rotation counter hands out time slots: each core owns one fixed position in a rotation of 16 clocks, and its slot positions are 2 clocks apart in core order. A core starts an access with a one-clock request pulse. The pulse carries a read or write command, an address and write data. The core then stalls until the rotation reaches the start of its own slot. The memory operation is done on that edge, and a fixed access time later the core gets a one-clock acknowledge. With the acknowledge come the read data and the total number of clocks the access took.

Slots belong to their owners even when nothing else is happening. A core that has just missed its slot waits for the whole rotation, while the memory sits idle and the other slots go unused. The time an access takes therefore depends on the core index and on the phase at which the request arrives. Cores that run identical code and are released together fall into step with the rotation after their first shared access. From then on their acknowledges come out staggered by one slot spacing.

Top module: `slot_arbiter`

## Requirements
- R1: In reset and until the first access completes, every ack_o bit is 0 and every cycles_o field is 0. The first clock edge after reset is released is rotation phase 0, and the phase rises by one on each edge after that.
- R2: The rotation lasts N_CORES*SLOT_CLKS = 16 clocks. The slot of core k starts at phase k*SLOT_CLKS (core k at phase 2k), and core k is granted only on such an edge.
- R3: A request is accepted on an edge where req_i[k] is 1 and core k has no access open. The command (we_i[k] = 1 for write, 0 for read; address; write data) is captured on that edge, so req_i may drop after one clock.
- R4: A request accepted at phase p is granted after (2k - p) mod 16 edges, a value from 0 to 15. A grant at wait 0 happens on the request edge itself.
- R5: ack_o[k] is high for exactly one clock. It rises after the edge that lies ACC_CLKS-1 (= 7) edges after the grant. In that cycle, cycles_o field k equals wait + ACC_CLKS (= wait + 8), and the field keeps that value until the next acknowledge of core k.
- R6: For a read, rdata_o field k holds, in the acknowledge cycle, the memory word at the captured address as it stood at the grant edge. The field keeps that value until the next acknowledge of core k.
- R7: For a write, the captured data is stored at the captured address on the grant edge, and any core can read it back afterwards.
- R8: An unused slot is never handed to another core. A core that has missed its slot waits for the full rotation even when no other core has an access open, and at most one core is granted per edge.
- R9: A request pulse on req_i[k] while core k has an access open is ignored: no extra acknowledge, and cycles_o is unchanged.
- R10: Cores that request on the same edge at phase p are acknowledged at (2k - p) mod 16 + 7 edges after that edge. With the rotation wrapping, the cores are served in slot order, one slot spacing apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_CORES | One-clock request pulse per core |
| we_i | input | N_CORES | Command per core: 1 write, 0 read |
| addr_i | input | N_CORES*ADDR_W | Word address per core, core k at bits k*ADDR_W upward |
| wdata_i | input | N_CORES*DATA_W | Write data per core |
| ack_o | output | N_CORES | One-clock acknowledge per core |
| rdata_o | output | N_CORES*DATA_W | Read data per core, valid in its acknowledge cycle |
| cycles_o | output | N_CORES*CYC_W | Clocks taken by the last access of each core |

## Verification
The bench builds the block with its defaults: eight cores, two clocks per slot, an access time of 8 clocks and a 64-word memory. This makes the rotation 16 phases long. With a rotation this short, every pairing of core index and request phase can be tried for both writes and reads: 8 cores times 16 phases. Each wait, acknowledge edge and cycle count is predicted from the modulo-16 formula. Writing through one core and reading back through another exercises the shared array. Separate runs release all eight cores on the same edge at different phases to check the staggered order, and send duplicate pulses while a core is waiting.

// File: rtl/slot_arbiter_pkg.sv
package slot_arbiter_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_BUSY = 2'd2
  } port_state_e;
endpackage

// File: rtl/slot_rotor.sv
module slot_rotor #(
  parameter int N_CORES   = 8,
  parameter int SLOT_CLKS = 2,
  localparam int ROT_LEN  = N_CORES * SLOT_CLKS,
  localparam int ROT_W    = $clog2(ROT_LEN)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [ROT_W-1:0]   rot_o,
  output logic [N_CORES-1:0] slot_start_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rot_o <= '0;
    else if (rot_o == ROT_W'(ROT_LEN - 1)) rot_o <= '0;
    else rot_o <= rot_o + 1'b1;
  end

  for (genvar k = 0; k < N_CORES; k++) begin : g_slot
    assign slot_start_o[k] = (rot_o == ROT_W'(k * SLOT_CLKS));
  end

  // R2: rotation closes after ROT_LEN phases
  p_rot_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rot_o == ROT_W'(ROT_LEN - 1)) |=> (rot_o == '0));
endmodule

// File: rtl/shared_ram.sv
module shared_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/core_port.sv
module core_port
  import slot_arbiter_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int CYC_W     = 5,
  parameter int ACC_CLKS  = 8,
  parameter int ROT_LEN   = 16,
  localparam int LAT_W    = $clog2(ACC_CLKS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              slot_start_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              grant_o,
  output logic              cmd_we_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_wdata_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CYC_W-1:0]  cycles_o
);
  port_state_e       state_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rbuf_q;
  logic [CYC_W-1:0]  cyc_q;
  logic [LAT_W-1:0]  lat_q;
  logic              accept, pending, done;

  assign accept  = (state_q == ST_IDLE) && req_i;
  assign pending = accept || (state_q == ST_WAIT);
  assign grant_o = pending && slot_start_i;
  assign done    = (state_q == ST_BUSY) && (lat_q == LAT_W'(ACC_CLKS - 1));

  // a wait-0 grant uses the live command
  assign cmd_we_o    = (state_q == ST_IDLE) ? we_i    : we_q;
  assign cmd_addr_o  = (state_q == ST_IDLE) ? addr_i  : addr_q;
  assign cmd_wdata_o = (state_q == ST_IDLE) ? wdata_i : wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      we_q     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rbuf_q   <= '0;
      cyc_q    <= '0;
      lat_q    <= '0;
      ack_o    <= 1'b0;
      rdata_o  <= '0;
      cycles_o <= '0;
    end else begin
      ack_o <= 1'b0;
      if (accept) begin
        we_q    <= we_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        cyc_q   <= CYC_W'(1);
      end else if (state_q != ST_IDLE) begin
        cyc_q <= cyc_q + 1'b1;
      end
      if (grant_o) begin
        lat_q <= LAT_W'(1);
        if (!cmd_we_o) rbuf_q <= mem_rdata_i;
      end else if (state_q == ST_BUSY) begin
        lat_q <= lat_q + 1'b1;
      end
      unique case (state_q)
        ST_IDLE: if (req_i) state_q <= grant_o ? ST_BUSY : ST_WAIT;
        ST_WAIT: if (grant_o) state_q <= ST_BUSY;
        ST_BUSY: if (done) begin
          state_q  <= ST_IDLE;
          ack_o    <= 1'b1;
          cycles_o <= cyc_q + 1'b1;
          if (!we_q) rdata_o <= rbuf_q;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5: acknowledge is a single clock
  p_ack_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  // R5: reported count within one rotation plus access time
  p_cycles_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (cycles_o >= CYC_W'(ACC_CLKS)) && (cycles_o <= CYC_W'(ROT_LEN - 1 + ACC_CLKS)));
  // R9: an open access never returns to idle without finishing
  p_wait_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |=> (state_q != ST_IDLE) && !ack_o);
endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter #(
  parameter int N_CORES   = 8,
  parameter int SLOT_CLKS = 2,
  parameter int ACC_CLKS  = 8,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  localparam int ROT_LEN  = N_CORES * SLOT_CLKS,
  localparam int ROT_W    = $clog2(ROT_LEN),
  localparam int CYC_W    = $clog2(ROT_LEN + ACC_CLKS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_CORES-1:0]          req_i,
  input  logic [N_CORES-1:0]          we_i,
  input  logic [N_CORES*ADDR_W-1:0]   addr_i,
  input  logic [N_CORES*DATA_W-1:0]   wdata_i,
  output logic [N_CORES-1:0]          ack_o,
  output logic [N_CORES*DATA_W-1:0]   rdata_o,
  output logic [N_CORES*CYC_W-1:0]    cycles_o
);
  logic [ROT_W-1:0]   rot;
  logic [N_CORES-1:0] slot_start;
  logic [N_CORES-1:0] grant;
  logic [N_CORES-1:0] c_we;
  logic [ADDR_W-1:0]  c_addr  [N_CORES];
  logic [DATA_W-1:0]  c_wdata [N_CORES];
  logic               m_we;
  logic [ADDR_W-1:0]  m_addr;
  logic [DATA_W-1:0]  m_wdata, m_rdata;

  slot_rotor #(.N_CORES(N_CORES), .SLOT_CLKS(SLOT_CLKS)) u_rotor (
    .clk_i, .rst_ni, .rot_o(rot), .slot_start_o(slot_start)
  );

  for (genvar k = 0; k < N_CORES; k++) begin : g_port
    core_port #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYC_W(CYC_W),
      .ACC_CLKS(ACC_CLKS), .ROT_LEN(ROT_LEN)
    ) u_port (
      .clk_i, .rst_ni,
      .req_i       (req_i[k]),
      .we_i        (we_i[k]),
      .addr_i      (addr_i[k*ADDR_W +: ADDR_W]),
      .wdata_i     (wdata_i[k*DATA_W +: DATA_W]),
      .slot_start_i(slot_start[k]),
      .mem_rdata_i (m_rdata),
      .grant_o     (grant[k]),
      .cmd_we_o    (c_we[k]),
      .cmd_addr_o  (c_addr[k]),
      .cmd_wdata_o (c_wdata[k]),
      .ack_o       (ack_o[k]),
      .rdata_o     (rdata_o[k*DATA_W +: DATA_W]),
      .cycles_o    (cycles_o[k*CYC_W +: CYC_W])
    );

    // R2: grant only at the owner's slot start
    p_grant_slot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant[k] |-> (rot == ROT_W'(k * SLOT_CLKS)));
  end

  // grants are one-hot by slot ownership
  always_comb begin
    m_we    = 1'b0;
    m_addr  = '0;
    m_wdata = '0;
    for (int k = 0; k < N_CORES; k++) begin
      if (grant[k]) begin
        m_we    = c_we[k];
        m_addr  = c_addr[k];
        m_wdata = c_wdata[k];
      end
    end
  end

  shared_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk_i, .wr_en_i(m_we), .addr_i(m_addr), .wdata_i(m_wdata), .rdata_o(m_rdata)
  );

  // R8: never more than one core on the memory
  p_grant_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
endmodule

// File: tb/slot_arbiter_test.sv
module slot_arbiter_test;
  localparam int N   = 8;
  localparam int AW  = 6;
  localparam int DW  = 32;
  localparam int CW  = 5;
  localparam int ROT = 16;
  localparam int ACC = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req = '0;
  logic [N-1:0]    we = '0;
  logic [N*AW-1:0] addr = '0;
  logic [N*DW-1:0] wdata = '0;
  logic [N-1:0]    ack;
  logic [N*DW-1:0] rdata;
  logic [N*CW-1:0] cycles;

  int checks = 0;
  int failures = 0;
  int edge_n = 0;

  always #5 clk = ~clk;
  always @(posedge clk) if (rst_n) edge_n <= edge_n + 1;

  slot_arbiter uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .cycles_o(cycles)
  );

  task automatic check(input bit ok, input string req_tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  function automatic int wait_of(input int k, input int p);
    return (2 * k - p + 2 * ROT) % ROT;
  endfunction

  function automatic logic [DW-1:0] pat(input int k, input int p, input int a);
    return 32'hA500_0000 ^ DW'(k << 8) ^ DW'(p) ^ DW'(a << 16);
  endfunction

  task automatic align(input int p);
    while ((edge_n % ROT) != p) @(negedge clk);
  endtask

  // one access by core k at phase p; dup sends a second pulse while open
  task automatic access(input int k, input bit w, input int a, input logic [DW-1:0] d,
                        input int p, input bit dup, input logic [DW-1:0] exp_rd);
    int e0, got, n_ack, ew;
    bit others;
    logic [CW-1:0] cyc_at;
    logic [DW-1:0] rd_at;
    align(p);
    e0 = edge_n;
    ew = wait_of(k, p);
    req[k] = 1'b1;
    we[k] = w;
    addr[k*AW +: AW] = AW'(a);
    wdata[k*DW +: DW] = d;
    @(negedge clk);
    req[k] = dup;
    we[k] = ~w;
    addr[k*AW +: AW] = ~AW'(a);
    wdata[k*DW +: DW] = ~d;
    got = -1; n_ack = 0; others = 1'b0; cyc_at = '0; rd_at = '0;
    for (int i = 0; i < 2 * ROT + ACC; i++) begin
      if (ack[k]) begin
        n_ack++;
        if (got < 0) begin
          got = edge_n - 1;
          cyc_at = cycles[k*CW +: CW];
          rd_at = rdata[k*DW +: DW];
        end
      end
      if ((ack & ~(N'(1) << k)) != '0) others = 1'b1;
      @(negedge clk);
      req[k] = 1'b0;
    end
    check(got == e0 + ew + ACC - 1, "R4 ack edge", got - e0, ew + ACC - 1);
    check(n_ack == 1, dup ? "R9 single ack" : "R5 single ack", n_ack, 1);
    check(cyc_at == CW'(ew + ACC), "R5 cycles", cyc_at, ew + ACC);
    check(cycles[k*CW +: CW] == CW'(ew + ACC), "R5 cycles held", cycles[k*CW +: CW], ew + ACC);
    check(!others, "R8 idle slots unused", others, 0);
    if (!w) check(rd_at == exp_rd, "R6 read data", rd_at, exp_rd);
  endtask

  task automatic together(input int p);
    int e0;
    int got [N];
    align(p);
    e0 = edge_n;
    for (int k = 0; k < N; k++) begin
      got[k] = -1;
      we[k] = 1'b0;
      addr[k*AW +: AW] = AW'(k);
    end
    req = '1;
    @(negedge clk);
    req = '0;
    for (int i = 0; i < 2 * ROT + ACC; i++) begin
      for (int k = 0; k < N; k++) if (ack[k] && got[k] < 0) got[k] = edge_n - 1 - e0;
      @(negedge clk);
    end
    for (int k = 0; k < N; k++)
      check(got[k] == wait_of(k, p) + ACC - 1, "R10 staggered ack", got[k], wait_of(k, p) + ACC - 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ack == '0, "R1 reset ack", ack, 0);
    check(cycles == '0, "R1 reset cycles", cycles, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ack == '0 && cycles == '0, "R1 idle after reset", ack, 0);
    // R2 R3 R4 R7: every core at every phase, write then cross-core read
    for (int k = 0; k < N; k++) begin
      for (int p = 0; p < ROT; p++) begin
        int a;
        a = (k * 8 + p) % (1 << AW);
        access(k, 1'b1, a, pat(k, p, a), p, p[0], '0);
        access((k + 3) % N, 1'b0, a, '0, (p + 5) % ROT, 1'b0, pat(k, p, a));
      end
    end
    // R10: all cores released on one edge
    for (int k = 0; k < N; k++) addr[k*AW +: AW] = AW'(k);
    together(0);
    together(5);
    together(15);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule